// File: doc/BRIEF.md
# Dual-Channel Fan Tachometer Capture Timer

This block measures fan speed by timing the interval between tachometer pulses. It holds two independent 16-bit down-counters, A and B. Both step on a shared tick made by dividing the bus clock with an 8-bit prescaler. Each counter watches one of up to sixteen fan pins, chosen by its own select register. When the watched pin shows the chosen edge, the counter's present value is latched into a capture register and a pending flag is raised. Software then reads the captured value and turns the elapsed count into a speed.

A stalled or missing fan produces no edges. To catch this, each counter can raise a timeout flag when its value equals a programmable compare value. Writing one to a capture flag's clear bit also reloads that counter to all ones, so the next interval starts from a known value. Six pending bits, an enable mask and a single interrupt line complete the block.

Registers sit at halfword offsets on a simple synchronous write / combinational read bus. The word index is `bus_addr[4:1]`. Writes to read-only registers have no effect.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset both counters read 0xFFFF; capture, compare, prescaler, clock-control, mode, compare-config, select, pending and interrupt-enable registers all read 0; `irq` is 0.
- R2: The registers sit at these byte offsets:
  - 0x00 counter A (read/write)
  - 0x06 counter B (read/write)
  - 0x02 capture A (read-only)
  - 0x04 capture B (read-only)
  - 0x08 prescaler, bits 7:0
  - 0x0A clock-control: bit 0 runs A, bit 3 runs B
  - 0x0C mode: bit 6 enables B, bit 5 enables A, bit 4 selects the B edge, bit 3 selects the A edge, bit 2 turns capture mode on
  - 0x0E pending (read-only)
  - 0x10 clear (write-only, reads 0)
  - 0x12 interrupt enable, bits 5:0
  - 0x14 compare A
  - 0x16 compare B
  - 0x18 compare-config: bit 2 enables compare on A, bit 6 enables compare on B
  - 0x1A select A, bits 3:0
  - 0x1C select B, bits 3:0

  Unlisted bits read 0.
- R3: While at least one clock-control run bit is set, a tick occurs once every (prescaler+1) bus clocks. A counter whose run bit is set decrements by one on each tick. A counter whose run bit is clear holds its value.
- R4: A counter that reaches 0 stays at 0 and does not wrap.
- R5: A capture on a channel happens when all of these hold:
  - capture mode (mode bit 2) is set;
  - the channel's enable bit is set;
  - the channel's run bit is set;
  - the selected pin shows the chosen edge, falling when the edge bit is 0 and rising when it is 1.

  On a capture the counter's value is stored in the capture register and pending bit 0 (A) or bit 1 (B) is set. The pin passes through a two-flop synchronizer, so a pin change made before clock edge k is captured at edge k+2.
- R6: Each channel watches only the fan pin whose number is in the low 4 bits of its select register. Edges on other pins have no effect.
- R7: When the channel's compare-config bit is set and the channel is running, a counter value equal to its compare value sets pending bit 4 (A) or bit 5 (B).
- R8: Writing the clear register clears each pending bit whose data bit is 1 and leaves the others unchanged. A flag set in the same cycle as its clear stays set. Pending bits 2 and 3 always read 0. Writes to the pending register are ignored.
- R9: A clear write with data bit 0 set reloads counter A to 0xFFFF; with data bit 1 set it reloads counter B to 0xFFFF. A counter whose capture bit is not cleared is untouched.
- R10: `irq` is high exactly when some pending bit and its interrupt-enable bit are both 1. Interrupt-enable bits keep their value until rewritten or reset.
- R11: A write to a counter register loads the written value into that counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the source of the prescaled tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte offset; bit 0 ignored |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not selected |
| fan_pins | input | 16 | Asynchronous tachometer inputs |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the points where this block is easy to get subtly wrong.

- Capture latency: the first clock edge after synchronization is where captures land. A design with one synchronizer stage too few or too many would latch a different count and set the flag in the wrong cycle.
- Zero hold: the counter is driven down to zero and left there. A design that wraps would read 0xFFFF.
- Set/clear race: a clear write is timed onto the exact cycle of a capture. A design that gives clear priority would lose the event.
- Reload and selection: the reload-on-clear and edge polarity are checked directly, and an unselected pin is toggled. A mux or polarity error would show as an extra or missing pending bit.

// File: rtl/tach_pkg.sv
package tach_pkg;
   // Word indices: byte offset = 2 * index
   localparam logic [3:0] W_CNT_A  = 4'd0;
   localparam logic [3:0] W_CAP_A  = 4'd1;
   localparam logic [3:0] W_CAP_B  = 4'd2;
   localparam logic [3:0] W_CNT_B  = 4'd3;
   localparam logic [3:0] W_PSC    = 4'd4;
   localparam logic [3:0] W_CLKCTL = 4'd5;
   localparam logic [3:0] W_MODE   = 4'd6;
   localparam logic [3:0] W_PEND   = 4'd7;
   localparam logic [3:0] W_CLR    = 4'd8;
   localparam logic [3:0] W_IEN    = 4'd9;
   localparam logic [3:0] W_CMP_A  = 4'd10;
   localparam logic [3:0] W_CMP_B  = 4'd11;
   localparam logic [3:0] W_CMPCFG = 4'd12;
   localparam logic [3:0] W_SEL_A  = 4'd13;
   localparam logic [3:0] W_SEL_B  = 4'd14;

   localparam int NUM_FLAGS = 6;
   localparam logic [3:0] CLKCTL_MASK = 4'b1001;
   localparam logic [6:0] MODE_MASK   = 7'b1111100;
   localparam logic [6:0] CMPCFG_MASK = 7'b1000100;

   function automatic logic edge_hit(input logic prev, input logic cur,
                                     input logic rise_sel);
      return rise_sel ? (!prev && cur) : (prev && !cur);
   endfunction
endpackage

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] div_q;

   assign tick = run && (div_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (!run)    div_q <= '0;
      else if (tick)    div_q <= '0;
      else              div_q <= div_q + 1'b1;
   end

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || div == '0)); // R3
endmodule

// File: rtl/tach_fan_sync.sv
module tach_fan_sync #(
   parameter int NUM_FANS    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FANS-1:0] pins,
   output logic [NUM_FANS-1:0] pins_sync
);
   logic [NUM_FANS-1:0] stg_q [SYNC_STAGES];

   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("tach_fan_sync: SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= pins;
         for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign pins_sync = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/tach_edge_pick.sv
module tach_edge_pick #(
   parameter int NUM_FANS = 16,
   parameter int SEL_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FANS-1:0] pins_sync,
   input  logic [SEL_W-1:0]    sel,
   input  logic                rise_sel,
   output logic                hit
);
   logic cur, prev_q;

   if ((1 << SEL_W) == NUM_FANS) begin : g_pow2
      assign cur = pins_sync[sel];
   end else begin : g_guard
      assign cur = (int'(sel) < NUM_FANS) ? pins_sync[sel] : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   assign hit = tach_pkg::edge_hit(prev_q, cur, rise_sel);
endmodule

// File: rtl/tach_channel.sv
module tach_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             arm,
   input  logic             hit,
   input  logic             cmp_en,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             reload,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap,
   output logic             cap_evt,
   output logic             to_evt
);
   localparam logic [CNT_W-1:0] FULL = '1;
   logic [CNT_W-1:0] cnt_q, cap_q;

   assign cap_evt = arm && run && hit;
   assign to_evt  = cmp_en && run && (cnt_q == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cnt_q <= FULL;
      else if (ld)                              cnt_q <= ld_val;
      else if (reload)                          cnt_q <= FULL;
      else if (run && tick && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cap_q <= '0;
      else if (cap_evt)  cap_q <= cnt_q;
   end

   assign cnt = cnt_q;
   assign cap = cap_q;

   AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !ld && !reload) |=> cnt_q == '0); // R4
   AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !ld) |=> cnt_q == FULL); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld && !reload) |=> $stable(cnt_q)); // R3
   AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> cap_q == $past(cnt_q)); // R5
endmodule

// File: rtl/tach_capture_timer.sv
module tach_capture_timer #(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 8,
   parameter int NUM_FANS    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [4:0]          bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_FANS-1:0] fan_pins,
   output logic                irq
);
   import tach_pkg::*;

   localparam int NCH   = 2;
   localparam int SEL_W = (NUM_FANS > 1) ? $clog2(NUM_FANS) : 1;

   if (CNT_W > DATA_W || DATA_W < 8 || PSC_W < 1 || PSC_W > DATA_W)
   begin : g_bad_width
      $error("tach_capture_timer: inconsistent width parameters");
   end
   if (NUM_FANS < 2 || SEL_W > 8) begin : g_bad_fans
      $error("tach_capture_timer: NUM_FANS out of range");
   end

   // register state
   logic [PSC_W-1:0]     psc_q;
   logic [3:0]           clkctl_q;
   logic [6:0]           mode_q;
   logic [6:0]           cmpcfg_q;
   logic [NUM_FLAGS-1:0] pend_q, ien_q;
   logic [CNT_W-1:0]     cmp_q [NCH];
   logic [SEL_W-1:0]     sel_q [NCH];

   logic       wsel;
   logic [3:0] widx;
   assign wsel = bus_sel && bus_wr;
   assign widx = bus_addr[4:1];

   logic wr_clr, wr_ien;
   assign wr_clr = wsel && widx == W_CLR;
   assign wr_ien = wsel && widx == W_IEN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q    <= '0;
         clkctl_q <= '0;
         mode_q   <= '0;
         cmpcfg_q <= '0;
         ien_q    <= '0;
         for (int c = 0; c < NCH; c++) begin
            cmp_q[c] <= '0;
            sel_q[c] <= '0;
         end
      end else if (wsel) begin
         case (widx)
            W_PSC:    psc_q    <= bus_wdata[PSC_W-1:0];
            W_CLKCTL: clkctl_q <= bus_wdata[3:0] & CLKCTL_MASK;
            W_MODE:   mode_q   <= bus_wdata[6:0] & MODE_MASK;
            W_CMPCFG: cmpcfg_q <= bus_wdata[6:0] & CMPCFG_MASK;
            W_IEN:    ien_q    <= bus_wdata[NUM_FLAGS-1:0];
            W_CMP_A:  cmp_q[0] <= bus_wdata[CNT_W-1:0];
            W_CMP_B:  cmp_q[1] <= bus_wdata[CNT_W-1:0];
            W_SEL_A:  sel_q[0] <= bus_wdata[SEL_W-1:0];
            W_SEL_B:  sel_q[1] <= bus_wdata[SEL_W-1:0];
            default: ;
         endcase
      end
   end

   // prescaled tick shared by both channels
   logic run_any, tick;
   assign run_any = clkctl_q[0] || clkctl_q[3];

   tach_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run_any), .div(psc_q), .tick(tick)
   );

   logic [NUM_FANS-1:0] pins_sync;
   tach_fan_sync #(.NUM_FANS(NUM_FANS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pins(fan_pins), .pins_sync(pins_sync)
   );

   logic [CNT_W-1:0] cnt_w [NCH];
   logic [CNT_W-1:0] cap_w [NCH];
   logic [NCH-1:0]   cap_evt, to_evt;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [3:0] MY_CNT = (c == 0) ? W_CNT_A : W_CNT_B;
      logic hit, run_c, ld_c;

      assign run_c = clkctl_q[3*c];
      assign ld_c  = wsel && widx == MY_CNT;

      tach_edge_pick #(.NUM_FANS(NUM_FANS), .SEL_W(SEL_W)) u_edge (
         .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync), .sel(sel_q[c]),
         .rise_sel(mode_q[3+c]), .hit(hit)
      );

      tach_channel #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .run(run_c), .tick(tick),
         .arm(mode_q[2] && mode_q[5+c]), .hit(hit),
         .cmp_en(cmpcfg_q[2+4*c]), .cmp_val(cmp_q[c]),
         .ld(ld_c), .ld_val(bus_wdata[CNT_W-1:0]),
         .reload(wr_clr && bus_wdata[c]),
         .cnt(cnt_w[c]), .cap(cap_w[c]),
         .cap_evt(cap_evt[c]), .to_evt(to_evt[c])
      );
   end

   // pending flags: set wins over a simultaneous clear
   logic [NUM_FLAGS-1:0] set_mask, clr_mask;
   assign set_mask = {to_evt[1], to_evt[0], 2'b00, cap_evt[1], cap_evt[0]};
   assign clr_mask = wr_clr ? bus_wdata[NUM_FLAGS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_mask) | set_mask;
   end

   assign irq = |(pend_q & ien_q);

   // read path
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr[4:1])
            W_CNT_A:  bus_rdata[CNT_W-1:0] = cnt_w[0];
            W_CNT_B:  bus_rdata[CNT_W-1:0] = cnt_w[1];
            W_CAP_A:  bus_rdata[CNT_W-1:0] = cap_w[0];
            W_CAP_B:  bus_rdata[CNT_W-1:0] = cap_w[1];
            W_CMP_A:  bus_rdata[CNT_W-1:0] = cmp_q[0];
            W_CMP_B:  bus_rdata[CNT_W-1:0] = cmp_q[1];
            W_PSC:    bus_rdata[PSC_W-1:0] = psc_q;
            W_CLKCTL: bus_rdata[3:0]       = clkctl_q;
            W_MODE:   bus_rdata[6:0]       = mode_q;
            W_CMPCFG: bus_rdata[6:0]       = cmpcfg_q;
            W_PEND:   bus_rdata[NUM_FLAGS-1:0] = pend_q;
            W_IEN:    bus_rdata[NUM_FLAGS-1:0] = ien_q;
            W_SEL_A:  bus_rdata[SEL_W-1:0] = sel_q[0];
            W_SEL_B:  bus_rdata[SEL_W-1:0] = sel_q[1];
            default:  bus_rdata = '0;
         endcase
      end
   end

   AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[0] |=> pend_q[0]); // R5
   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && bus_wdata[1] && !cap_evt[1]) |=> !pend_q[1]); // R8
   AST_IEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ien |=> $stable(ien_q)); // R10
endmodule

// File: tb/tach_capture_timer_test.sv
module tach_capture_timer_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] fan_pins = 16'hFFFF;
   logic        irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   tach_capture_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fan_pins(fan_pins), .irq(irq)
   );

   int total = 0, bad = 0;
   bit done = 0;

   // ---------------- behavioural reference ----------------
   int m_psc, m_div, m_cc, m_mode, m_cfg, m_pend, m_ien;
   int m_cnt [2];
   int m_cap [2];
   int m_cmp [2];
   int m_sel [2];
   bit m_prev [2];
   logic [15:0] m_hist [$];

   function automatic bit bitof(int v, int b);
      return ((v >> b) & 1) != 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_psc = 0; m_div = 0; m_cc = 0; m_mode = 0; m_cfg = 0;
         m_pend = 0; m_ien = 0;
         for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 16'hFFFF; m_cap[c] = 0; m_cmp[c] = 0;
            m_sel[c] = 0; m_prev[c] = 0;
         end
         m_hist.delete(); m_hist.push_back(16'h0); m_hist.push_back(16'h0);
      end else begin
         logic [15:0] syncv;
         bit tick, wr;
         int wa, wd, setm, clrm;
         int n_cnt [2];
         bit cur [2];
         syncv = m_hist[m_hist.size()-2];
         wr = bus_sel && bus_wr;
         wa = int'(bus_addr) & 'h1E;
         wd = int'(bus_wdata);
         tick = (m_cc != 0) && (m_div >= m_psc);
         setm = 0;
         clrm = (wr && wa == 'h10) ? (wd & 'h3F) : 0;
         for (int c = 0; c < 2; c++) begin
            bit run, hit;
            run = bitof(m_cc, 3*c);
            cur[c] = syncv[m_sel[c]];
            hit = bitof(m_mode, 3+c) ? (!m_prev[c] && cur[c]) : (m_prev[c] && !cur[c]);
            if (hit && run && bitof(m_mode, 2) && bitof(m_mode, 5+c)) begin
               setm |= (1 << c);
               m_cap[c] = m_cnt[c];
            end
            if (bitof(m_cfg, 2+4*c) && run && m_cnt[c] == m_cmp[c]) setm |= (1 << (4+c));
            n_cnt[c] = m_cnt[c];
            if (wr && wa == (c == 0 ? 'h00 : 'h06)) n_cnt[c] = wd;
            else if (bitof(clrm, c)) n_cnt[c] = 'hFFFF;
            else if (run && tick && m_cnt[c] != 0) n_cnt[c] = m_cnt[c] - 1;
         end
         m_pend = (m_pend & ~clrm) | setm;
         if (m_cc == 0 || tick) m_div = 0; else m_div = m_div + 1;
         for (int c = 0; c < 2; c++) begin
            m_cnt[c] = n_cnt[c];
            m_prev[c] = cur[c];
         end
         if (wr) begin
            case (wa)
               'h08: m_psc = wd & 'hFF;
               'h0A: m_cc = wd & 'h09;
               'h0C: m_mode = wd & 'h7C;
               'h12: m_ien = wd & 'h3F;
               'h14: m_cmp[0] = wd;
               'h16: m_cmp[1] = wd;
               'h18: m_cfg = wd & 'h44;
               'h1A: m_sel[0] = wd & 'hF;
               'h1C: m_sel[1] = wd & 'hF;
               default: ;
            endcase
         end
         m_hist.push_back(fan_pins);
         if (m_hist.size() > 3) void'(m_hist.pop_front());
      end
   end

   function automatic int mread(int a);
      case (a & 'h1E)
         'h00: return m_cnt[0];
         'h02: return m_cap[0];
         'h04: return m_cap[1];
         'h06: return m_cnt[1];
         'h08: return m_psc;
         'h0A: return m_cc;
         'h0C: return m_mode;
         'h0E: return m_pend;
         'h12: return m_ien;
         'h14: return m_cmp[0];
         'h16: return m_cmp[1];
         'h18: return m_cfg;
         'h1A: return m_sel[0];
         'h1C: return m_sel[1];
         default: return 0;
      endcase
   endfunction

   // ---------------- checking helpers ----------------
   task automatic check(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e;
         e = (m_pend & m_ien) != 0;
         check(irq == e, "R10 irq vs model", int'(irq), int'(e));
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 5'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd_model(int a, string tag);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = 5'(a);
      #1;
      check(int'(bus_rdata) == mread(a), tag, int'(bus_rdata), mread(a));
      bus_sel = 0;
   endtask

   task automatic rd_fixed(int a, int exp, string tag);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = 5'(a);
      #1;
      check(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
      bus_sel = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      for (int a = 0; a <= 'h1C; a += 2) rd_model(a, "R1 reset value");
      rd_fixed('h00, 'hFFFF, "R1 counter A reset");
      rd_fixed('h0E, 0, "R1 pending reset");
      check(irq == 1'b0, "R1 irq reset", int'(irq), 0);

      // R2 masks and read-only slots
      wr('h08, 'h1AB); rd_fixed('h08, 'hAB, "R2 prescaler width");
      wr('h0C, 'hFF);  rd_fixed('h0C, 'h7C, "R2 mode mask");
      wr('h18, 'hFF);  rd_fixed('h18, 'h44, "R2 compare-config mask");
      wr('h1A, 'h1F);  rd_fixed('h1A, 'h0F, "R2 select width");
      wr('h02, 'h1234); rd_fixed('h02, 0, "R2 capture read-only");
      wr('h0E, 'h3F);  rd_fixed('h0E, 0, "R8 pending not writable");
      rd_fixed('h10, 0, "R2 clear reads zero");
      wr('h0C, 0); wr('h18, 0); wr('h1A, 0);

      // R11 load
      wr('h00, 'h0123); rd_fixed('h00, 'h0123, "R11 counter A load");
      wr('h06, 'h0456); rd_fixed('h06, 'h0456, "R11 counter B load");

      // R3 prescaled count, only A running
      wr('h08, 3); wr('h00, 100); wr('h0A, 'h01);
      idle(40);
      rd_model('h00, "R3 counter A after prescaled run");
      wr('h0A, 0);
      rd_model('h00, "R3 counter A stopped");
      rd_fixed('h06, 'h0456, "R3 counter B idle holds");

      // R4 hold at zero
      wr('h08, 0); wr('h00, 5); wr('h0A, 'h01);
      idle(20);
      rd_fixed('h00, 0, "R4 counter holds at zero");
      wr('h0A, 0);

      // R5 capture, falling on A, rising on B
      wr('h00, 'h4000); wr('h06, 'h4000);
      wr('h1A, 3); wr('h1C, 7);
      wr('h0C, 'h74); wr('h0A, 'h09);
      @(negedge clk); fan_pins[3] = 1'b0;
      idle(6);
      rd_model('h02, "R5 capture A value");
      rd_model('h0E, "R5 pending after A capture");
      @(negedge clk); fan_pins[7] = 1'b0;
      idle(6);
      rd_fixed('h0E, 'h01, "R5 falling edge ignored in rising mode");
      @(negedge clk); fan_pins[7] = 1'b1;
      idle(6);
      rd_fixed('h0E, 'h03, "R5 rising capture on B");
      rd_model('h04, "R5 capture B value");

      // R6 unselected pin ignored
      wr('h10, 'h03);
      wr('h1A, 5);
      @(negedge clk); fan_pins[3] = 1'b1;
      idle(4);
      @(negedge clk); fan_pins[3] = 1'b0;
      idle(6);
      rd_fixed('h0E, 0, "R6 unselected pin ignored");
      @(negedge clk); fan_pins[5] = 1'b0;
      idle(6);
      rd_fixed('h0E, 'h01, "R6 selected pin captured");

      // R8 set and clear in the same cycle
      @(negedge clk); fan_pins[5] = 1'b1;
      idle(4);
      wr('h10, 'h01);
      rd_fixed('h0E, 0, "R8 clear removes flag");
      @(negedge clk); fan_pins[5] = 1'b0;
      @(negedge clk);
      wr('h10, 'h01);
      rd_fixed('h0E, 'h01, "R8 set wins over clear");
      rd_model('h00, "R8 counter after race");

      // R9 reload on clear
      wr('h0A, 0);
      wr('h00, 'h0010); wr('h06, 'h0020);
      wr('h10, 'h01);
      rd_fixed('h00, 'hFFFF, "R9 counter A reloaded");
      rd_fixed('h06, 'h0020, "R9 counter B untouched");
      rd_fixed('h0E, 0, "R8 flag cleared");

      // R7 compare timeout on A
      wr('h0C, 0);
      wr('h00, 20); wr('h14, 15); wr('h18, 'h04); wr('h08, 1);
      wr('h0A, 'h01);
      idle(30);
      rd_fixed('h0E, 'h10, "R7 timeout A flagged, B clear");
      rd_model('h00, "R7 counter keeps running");

      // R10 interrupt and enable retention
      wr('h12, 'h10);
      @(negedge clk);
      check(irq == 1'b1, "R10 irq raised", int'(irq), 1);
      wr('h10, 'h10);
      @(negedge clk);
      check(irq == 1'b0, "R10 irq dropped after clear", int'(irq), 0);
      wr('h08, 7); wr('h1C, 2);
      rd_fixed('h12, 'h10, "R10 enable retained");
      wr('h0A, 0);
      idle(3);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule